// File: doc/BRIEF.md
# Cycle-by-Cycle Overcurrent Limiter

This block sits in the gate path of a switching converter, between the pulse request and the drive output. While the switch is on, it watches two current-sense comparators. One marks the ordinary current limit and the other a much higher, severe level. If the ordinary limit is crossed, the present on-pulse is cut short and the block waits for the next request pulse. If the severe level is crossed, all switching is held off for a fixed number of clocks before the block tries again.

Both comparator inputs are asynchronous, so each passes through a two-flop synchronizer. The current spike at switch turn-on would otherwise look like a fault, so sensing is masked for a programmable number of cycles after each rising edge of the request. A truncated pulse never resumes inside the same request. A request that is already high when the hold-off ends also stays off. In both cases the drive is released only after the request has been low for at least one clock and then rises again. The blanking length and the hold-off length are parameters counted in clock cycles.

Top module: `pulse_current_guard`

## Requirements
- R1: With no fault pending, `gateOut` equals `gateReq` in the same cycle, including at turn-on.
- R2: Comparator activity is ignored while `gateReq` has been high for no more than `BLANK_CYC` clock edges since it last rose.
- R3: Comparator activity is ignored while `gateReq` is low, and it leaves no effect on later pulses.
- R4: A limit comparator that rises after blanking forces `gateOut` low on the third rising clock edge after the comparator is first sampled high.
- R5: Once a pulse has been truncated, `gateOut` stays low while `gateReq` stays high. The drive returns only after `gateReq` has been sampled low for at least one clock and then rises again.
- R6: `cycLimit` is high for exactly one clock per truncated pulse, on the cycle in which `gateOut` first goes low.
- R7: A clamp comparator that rises after blanking forces `gateOut` low with the same three-edge latency as R4. It then holds `restartOn` high for exactly `HOLD_CYC` consecutive cycles.
- R8: While `restartOn` is high, `gateOut` stays low for any `gateReq`. A request that is still high when the hold-off ends stays off until it falls and rises again.
- R9: When both comparators trip in the same cycle, the clamp response wins: `restartOn` rises and `cycLimit` does not pulse.
- R10: While `rstN` is low and right after it is released, `cycLimit` and `restartOn` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| gateReq | input | 1 | Pulse request from the modulator, high means switch on |
| limTrip | input | 1 | Asynchronous comparator output for the ordinary current limit |
| clampTrip | input | 1 | Asynchronous comparator output for the severe current level |
| gateOut | output | 1 | Gated drive to the switch |
| cycLimit | output | 1 | One-clock pulse for each truncated pulse |
| restartOn | output | 1 | High for the whole switching hold-off |

## Verification
The ordinary-limit truncation and the severe-level escalation can both fire on the same evaluation edge, because the two comparators are synchronized in parallel and sampled under the same blanking gate. The case is provoked by raising both comparator inputs on one clock edge, once the blanking window of a long request has expired. It is judged at the ports: `restartOn` must be high on the third edge, and no `cycLimit` pulse may appear at any point in the sequence. The hold-off that follows must also last its full length.

// File: rtl/ocg_pkg.sv
package ocg_pkg;

  // Strobes from the control FSM into the counters of the datapath
  typedef struct packed {
    logic blankClr;  // request is low: restart the blanking count
    logic holdLoad;  // severe trip: start the hold-off count from zero
    logic holdRun;   // hold-off active: advance the hold-off count
  } ocgStrobe_t;

  function automatic int unsigned minWidth(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/ocg_sync.sv
module ocg_sync #(
  parameter int unsigned WIDTH  = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);

  logic [WIDTH-1:0] stageQ [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) stageQ[0] <= '0;
          else       stageQ[0] <= asyncIn;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) stageQ[s] <= '0;
          else       stageQ[s] <= stageQ[s-1];
        end
      end
    end
  endgenerate

  assign syncOut = stageQ[STAGES-1];

endmodule

// File: rtl/ocg_datapath.sv
module ocg_datapath
  import ocg_pkg::*;
#(
  parameter int unsigned BLANK_CYC   = 38,
  parameter int unsigned HOLD_CYC    = 200000,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       limTrip,
  input  logic       clampTrip,
  input  ocgStrobe_t stb,
  output logic       limSync,
  output logic       clampSync,
  output logic       blankDone,
  output logic       holdDone
);

  localparam int unsigned BW = minWidth(BLANK_CYC + 1);
  localparam int unsigned HW = minWidth(HOLD_CYC);
  localparam logic [BW-1:0] BLANK_END = BW'(BLANK_CYC);
  localparam logic [HW-1:0] HOLD_END  = HW'(HOLD_CYC - 1);

  logic [1:0]    tripSync;
  logic [BW-1:0] blankCnt;
  logic [HW-1:0] holdCnt;

  ocg_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) sync_i (
    .clk     (clk),
    .rstN    (rstN),
    .asyncIn ({clampTrip, limTrip}),
    .syncOut (tripSync)
  );

  assign limSync   = tripSync[0];
  assign clampSync = tripSync[1];

  // Counts clock edges with the request high, saturating at the window end
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                    blankCnt <= '0;
    else if (stb.blankClr)        blankCnt <= '0;
    else if (blankCnt != BLANK_END) blankCnt <= blankCnt + 1'b1;
  end

  assign blankDone = (blankCnt == BLANK_END);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            holdCnt <= '0;
    else if (stb.holdLoad) holdCnt <= '0;
    else if (stb.holdRun && holdCnt != HOLD_END) holdCnt <= holdCnt + 1'b1;
  end

  assign holdDone = (holdCnt == HOLD_END);

endmodule

// File: rtl/ocg_control.sv
module ocg_control
  import ocg_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       gateReq,
  input  logic       limSync,
  input  logic       clampSync,
  input  logic       blankDone,
  input  logic       holdDone,
  output ocgStrobe_t stb,
  output logic       gateOut,
  output logic       cycLimit,
  output logic       restartOn
);

  logic cutQ;
  logic holdQ;
  logic senseEn;
  logic clampHit;
  logic limHit;

  // Sense only while the switch is on and past blanking
  assign senseEn  = gateReq && blankDone && !cutQ && !holdQ;
  assign clampHit = senseEn && clampSync;
  assign limHit   = senseEn && limSync && !clampSync;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cutQ     <= 1'b0;
      holdQ    <= 1'b0;
      cycLimit <= 1'b0;
    end else begin
      cycLimit <= limHit;
      if (clampHit)              holdQ <= 1'b1;
      else if (holdQ && holdDone) holdQ <= 1'b0;
      if (clampHit || limHit)    cutQ <= 1'b1;
      else if (!gateReq && !holdQ) cutQ <= 1'b0;
    end
  end

  assign gateOut   = gateReq && !cutQ && !holdQ;
  assign restartOn = holdQ;

  always_comb begin
    stb          = '0;
    stb.blankClr = !gateReq;
    stb.holdLoad = clampHit;
    stb.holdRun  = holdQ;
  end

endmodule

// File: rtl/pulse_current_guard.sv
module pulse_current_guard
  import ocg_pkg::*;
#(
  parameter int unsigned BLANK_CYC   = 38,
  parameter int unsigned HOLD_CYC    = 200000,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic gateReq,
  input  logic limTrip,
  input  logic clampTrip,
  output logic gateOut,
  output logic cycLimit,
  output logic restartOn
);

  ocgStrobe_t stb;
  logic limSync, clampSync, blankDone, holdDone;

  ocg_datapath #(
    .BLANK_CYC   (BLANK_CYC),
    .HOLD_CYC    (HOLD_CYC),
    .SYNC_STAGES (SYNC_STAGES)
  ) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .limTrip   (limTrip),
    .clampTrip (clampTrip),
    .stb       (stb),
    .limSync   (limSync),
    .clampSync (clampSync),
    .blankDone (blankDone),
    .holdDone  (holdDone)
  );

  ocg_control ctl_i (
    .clk       (clk),
    .rstN      (rstN),
    .gateReq   (gateReq),
    .limSync   (limSync),
    .clampSync (clampSync),
    .blankDone (blankDone),
    .holdDone  (holdDone),
    .stb       (stb),
    .gateOut   (gateOut),
    .cycLimit  (cycLimit),
    .restartOn (restartOn)
  );

endmodule

// File: rtl/ocg_checker.sv
module ocg_checker #(
  parameter int unsigned BLANK_CYC = 38
) (
  input logic clk,
  input logic rstN,
  input logic gateReq,
  input logic gateOut,
  input logic cycLimit,
  input logic restartOn
);

  localparam int unsigned CW = (BLANK_CYC + 2 > 1) ? $clog2(BLANK_CYC + 2) : 1;
  localparam logic [CW-1:0] CMAX = CW'(BLANK_CYC + 1);

  // Own count of edges seen with the request high
  logic [CW-1:0] hiCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         hiCnt <= '0;
    else if (!gateReq) hiCnt <= '0;
    else if (hiCnt != CMAX) hiCnt <= hiCnt + 1'b1;
  end

  // R2
  no_early_limit_chk: assert property (@(posedge clk) disable iff (!rstN)
    cycLimit |-> (hiCnt == CMAX));

  // R2
  no_early_clamp_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(restartOn) |-> (hiCnt == CMAX));

  // R4
  limit_cuts_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    cycLimit |-> !gateOut);

  // R5
  stays_cut_chk: assert property (@(posedge clk) disable iff (!rstN)
    (gateReq && $past(gateReq) && !$past(gateOut)) |-> !gateOut);

  // R6
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    cycLimit |=> !cycLimit);

  // R8
  hold_blocks_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    restartOn |-> !gateOut);

  // R9
  clamp_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(restartOn) |-> !cycLimit);

endmodule

bind pulse_current_guard ocg_checker #(.BLANK_CYC(BLANK_CYC)) chk_i (
  .clk       (clk),
  .rstN      (rstN),
  .gateReq   (gateReq),
  .gateOut   (gateOut),
  .cycLimit  (cycLimit),
  .restartOn (restartOn)
);

// File: tb/pulse_current_guard_tb_top.sv
module pulse_current_guard_tb_top;

  localparam int unsigned BLANK = 6;
  localparam int unsigned HOLD  = 50;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic gateReq = 1'b0;
  logic limTrip = 1'b0;
  logic clampTrip = 1'b0;
  logic gateOut, cycLimit, restartOn;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  pulse_current_guard #(.BLANK_CYC(BLANK), .HOLD_CYC(HOLD)) dut_i (
    .clk       (clk),
    .rstN      (rstN),
    .gateReq   (gateReq),
    .limTrip   (limTrip),
    .clampTrip (clampTrip),
    .gateOut   (gateOut),
    .cycLimit  (cycLimit),
    .restartOn (restartOn)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic expectPins(input string tag, input bit g, input bit c, input bit r);
    #1;
    check(gateOut == g,   {tag, " gateOut"},   gateOut, g);
    check(cycLimit == c,  {tag, " cycLimit"},  cycLimit, c);
    check(restartOn == r, {tag, " restartOn"}, restartOn, r);
  endtask

  task automatic t_reset();
    repeat (3) step();
    expectPins("R10 in reset", 0, 0, 0);
    rstN = 1'b1;
    step();
    expectPins("R10 after reset", 0, 0, 0);
  endtask

  task automatic t_pass();
    int bad = 0;
    step();
    gateReq = 1'b1;
    expectPins("R1 turn-on", 1, 0, 0);
    for (int i = 0; i < 20; i++) begin
      step();
      if (!gateOut || cycLimit) bad++;
    end
    check(bad == 0, "R1 held pulse", bad, 0);
    gateReq = 1'b0;
    expectPins("R1 turn-off", 0, 0, 0);
    step();
  endtask

  task automatic t_blank();
    int bad = 0;
    step();
    gateReq = 1'b1; limTrip = 1'b1; clampTrip = 1'b1;
    for (int i = 0; i < BLANK - 2; i++) begin
      step();
      if (!gateOut) bad++;
    end
    limTrip = 1'b0; clampTrip = 1'b0;
    for (int i = 0; i < 16; i++) begin
      step();
      if (!gateOut || cycLimit || restartOn) bad++;
    end
    check(bad == 0, "R2 spike in blanking ignored", bad, 0);
    gateReq = 1'b0;
    step();
    // limit held from turn-on: cut lands on edge BLANK+1
    gateReq = 1'b1; limTrip = 1'b1;
    for (int i = 0; i < BLANK; i++) step();
    expectPins("R2 last blank edge", 1, 0, 0);
    step();
    expectPins("R2 first sensed edge", 0, 1, 0);
    limTrip = 1'b0; gateReq = 1'b0;
    step(); step();
  endtask

  task automatic t_offIgnore();
    int bad = 0;
    step();
    limTrip = 1'b1; clampTrip = 1'b1;
    for (int i = 0; i < 10; i++) begin
      step();
      if (gateOut || cycLimit || restartOn) bad++;
    end
    limTrip = 1'b0; clampTrip = 1'b0;
    repeat (3) step();
    gateReq = 1'b1;
    for (int i = 0; i < 15; i++) begin
      step();
      if (!gateOut || cycLimit || restartOn) bad++;
    end
    check(bad == 0, "R3 trips while off ignored", bad, 0);
    gateReq = 1'b0;
    step();
  endtask

  task automatic t_limit();
    int pulses = 0;
    int bad = 0;
    step();
    gateReq = 1'b1;
    repeat (10) step();
    limTrip = 1'b1;
    step(); expectPins("R4 edge1", 1, 0, 0);
    step(); expectPins("R4 edge2", 1, 0, 0);
    step(); expectPins("R4 R6 edge3 cut", 0, 1, 0);
    pulses++;
    step(); expectPins("R6 pulse ends", 0, 0, 0);
    limTrip = 1'b0;
    for (int i = 0; i < 10; i++) begin
      step();
      if (gateOut) bad++;
      if (cycLimit) pulses++;
    end
    check(bad == 0, "R5 stays off while request high", bad, 0);
    check(pulses == 1, "R6 one pulse per truncation", pulses, 1);
    gateReq = 1'b0;
    step();
    gateReq = 1'b1;
    expectPins("R5 new pulse drives", 1, 0, 0);
    step();
    gateReq = 1'b0;
    step();
  endtask

  task automatic t_clamp();
    int hiCycles = 0;
    int bad = 0;
    step();
    gateReq = 1'b1;
    repeat (10) step();
    clampTrip = 1'b1;
    step(); step();
    expectPins("R7 edge2", 1, 0, 0);
    step();
    expectPins("R7 edge3", 0, 0, 1);
    clampTrip = 1'b0;
    hiCycles = 1;
    for (int i = 0; i < 200 && restartOn; i++) begin
      if (i == 5)  gateReq = 1'b0;
      if (i == 10) gateReq = 1'b1;
      if (i == 20) gateReq = 1'b0;
      if (i == 30) gateReq = 1'b1;
      step();
      #1;
      if (gateOut) bad++;
      if (restartOn) hiCycles++;
    end
    check(hiCycles == HOLD, "R7 hold-off length", hiCycles, HOLD);
    check(bad == 0, "R8 gate low during hold", bad, 0);
    step();
    expectPins("R8 request spanning hold stays off", 0, 0, 0);
    gateReq = 1'b0;
    step();
    gateReq = 1'b1;
    expectPins("R8 fresh request after hold", 1, 0, 0);
    step();
    gateReq = 1'b0;
    step();
  endtask

  task automatic t_both();
    int pulses = 0;
    step();
    gateReq = 1'b1;
    repeat (10) step();
    limTrip = 1'b1; clampTrip = 1'b1;
    step(); step(); step();
    expectPins("R9 clamp wins", 0, 0, 1);
    limTrip = 1'b0; clampTrip = 1'b0;
    gateReq = 1'b0;
    for (int i = 0; i < 200 && restartOn; i++) begin
      step();
      #1;
      if (cycLimit) pulses++;
    end
    check(pulses == 0, "R9 no limit pulse", pulses, 0);
    check(restartOn == 1'b0, "R9 hold ends", restartOn, 0);
    step();
  endtask

  initial begin
    t_reset();
    t_pass();
    t_blank();
    t_offIgnore();
    t_limit();
    t_clamp();
    t_both();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule